// File: doc/BRIEF.md
# Packet-Aware Dual-Clock FIFO

This block moves packets of data words from a write clock domain to a read clock domain whose clocks run at nominally the same rate from separate oscillators. The writer presents one word per cycle for the whole of a packet and only pauses between packets; every word carries an end-of-packet marker that is stored next to it. Pointers cross between the domains as gray code through two-flop synchronizers.

The read side is a small state machine that decides when a packet may begin. In `RD_IDLE` it waits until the consumer raises `rd_accept` and at least two words are visible. It then pops the first word and moves to `RD_STREAM`, or stays in `RD_IDLE` when that word already ends a packet. In `RD_STREAM` it pops one word every read cycle and returns to `RD_IDLE` on the word that carries the end marker. If the FIFO runs dry mid-packet it moves to `RD_STARVED` and raises a sticky underflow flag. From there it goes back to `RD_STREAM` (or to `RD_IDLE` on a final word) as soon as a word becomes visible. The empty and almost-empty flags are computed in the read domain, so they can be late to fall but are never late to rise. Writes that arrive while the FIFO is full are dropped and set a sticky overflow flag. One active-low reset clears both domains.

Top module: `pcf_top`

## Requirements
- R1: Words leave the read port in the order they were written, each with its data and end marker unchanged (`rd_last` is 1 on the word written with `wr_last` = 1).
- R2: A packet is started only while `rd_accept` is 1 and at least two words are visible in the read domain; a single buffered word is held back and `rd_valid` stays 0.
- R3: Once a packet has started, `rd_valid` is 1 on every read cycle until the word with the end marker, provided the writer keeps one word per cycle.
- R4: `rd_empty` is 1 exactly when the read-domain occupancy is zero, and it follows a write within three read cycles.
- R5: `rd_aempty` is 1 whenever the read-domain occupancy is zero or one, both while the FIFO fills from empty and while it drains.
- R6: `wr_full` is 1 when DEPTH words are held; a write while full is discarded and sets `wr_overflow`, which stays at 1 until reset.
- R7: If no word is available mid-packet, `rd_underflow` is set and stays at 1 until reset, and the packet resumes once words arrive.
- R8: `rd_accept` has no effect once a packet has started; the rest of the packet is still delivered.
- R9: Reset clears both pointers and all flags: `rd_empty` = 1, `rd_aempty` = 1, `rd_valid` = 0, `wr_full` = 0, `wr_overflow` = 0, `rd_underflow` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Active-low reset for both domains |
| wr_valid | input | 1 | Push one word this write cycle |
| wr_data | input | DW | Word to store |
| wr_last | input | 1 | Word ends its packet |
| wr_full | output | 1 | DEPTH words held, as seen from the write domain |
| wr_overflow | output | 1 | Sticky: a push arrived while full |
| rd_accept | input | 1 | Consumer can take a new packet |
| rd_valid | output | 1 | Word on rd_data this read cycle |
| rd_data | output | DW | Popped word |
| rd_last | output | 1 | Popped word ends its packet |
| rd_empty | output | 1 | No word visible in the read domain |
| rd_aempty | output | 1 | At most one word visible in the read domain |
| rd_underflow | output | 1 | Sticky: a pop was due mid-packet with nothing buffered |

## Verification
A wrong read state shows up at the ports within one read cycle. A packet started on a single word produces a gap in `rd_valid` followed by `rd_underflow`. A state that fails to return to `RD_IDLE` on the end marker makes the next packet start without the two-word check. A bad pointer or a bad crossing shows up at the ports a few read cycles after the write. Words can be lost, repeated or reordered, and `rd_empty` and `rd_aempty` then disagree with the occupancy the bench counts itself while it fills and drains the FIFO one word at a time.

// File: rtl/pcf_pkg.sv
package pcf_pkg;

    typedef enum logic [1:0] {
        RD_IDLE    = 2'd0,
        RD_STREAM  = 2'd1,
        RD_STARVED = 2'd2
    } rd_state_t;

endpackage

// File: rtl/pcf_sync.sv
module pcf_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pcf_mem.sv
module pcf_mem #(
    parameter int W  = 9,
    parameter int AW = 3
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] store [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/pcf_wr_ctl.sv
module pcf_wr_ctl #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW:0]   rgray_sync,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          full,
    output logic          overflow
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_n;
    logic [PW-1:0] rbin_seen;
    logic [PW-1:0] used;

    always_comb begin
        rbin_seen[PW-1] = rgray_sync[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            rbin_seen[i] = rbin_seen[i+1] ^ rgray_sync[i];
        end
    end

    assign used   = wbin - rbin_seen;
    assign full   = used[PW-1];
    assign we     = push && !full;
    assign wbin_n = wbin + {{AW{1'b0}}, we};
    assign waddr  = wbin[AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin     <= '0;
            wgray    <= '0;
            overflow <= 1'b0;
        end else begin
            wbin     <= wbin_n;
            wgray    <= wbin_n ^ (wbin_n >> 1);
            overflow <= overflow || (push && full);
        end
    end

    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> $stable(wgray)); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R6
endmodule

// File: rtl/pcf_rd_ctl.sv
module pcf_rd_ctl
    import pcf_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW:0]   wgray_sync,
    input  logic [DW:0]   head,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          rd_last,
    output logic          empty,
    output logic          aempty,
    output logic          underflow
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] ONE     = PW'(1);
    localparam logic [PW-1:0] DEPTH_C = PW'(DEPTH);

    rd_state_t     state;
    rd_state_t     state_n;
    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_n;
    logic [PW-1:0] wbin_seen;
    logic [PW-1:0] occ;
    logic          pop;
    logic          head_last;

    always_comb begin
        wbin_seen[PW-1] = wgray_sync[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            wbin_seen[i] = wbin_seen[i+1] ^ wgray_sync[i];
        end
    end

    assign occ       = wbin_seen - rbin;
    assign empty     = (occ == '0);
    assign aempty    = (occ <= ONE);
    assign head_last = head[DW];
    assign raddr     = rbin[AW-1:0];
    assign rbin_n    = rbin + {{AW{1'b0}}, pop};

    // next state and pop decision
    always_comb begin
        pop     = 1'b0;
        state_n = state;
        unique case (state)
            RD_IDLE: begin
                if (accept && (occ > ONE)) begin
                    pop     = 1'b1;
                    state_n = head_last ? RD_IDLE : RD_STREAM;
                end
            end
            RD_STREAM, RD_STARVED: begin
                if (occ != '0) begin
                    pop     = 1'b1;
                    state_n = head_last ? RD_IDLE : RD_STREAM;
                end else begin
                    state_n = RD_STARVED;
                end
            end
            default: state_n = RD_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RD_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // pointer register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_n;
            rgray <= rbin_n ^ (rbin_n >> 1);
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            rd_last   <= 1'b0;
            underflow <= 1'b0;
        end else begin
            rd_valid  <= pop;
            if (pop) begin
                rd_data <= head[DW-1:0];
                rd_last <= head_last;
            end
            underflow <= underflow || ((state != RD_IDLE) && (occ == '0));
        end
    end

    AST_GRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wgray_sync ^ $past(wgray_sync)) <= 1); // R4
    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH_C); // R1
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_last) |-> (state == RD_IDLE)); // R3
    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow); // R7
    AST_EMPTY_IN_AEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> aempty); // R5
endmodule

// File: rtl/pcf_top.sv
module pcf_top #(
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_last,
    output logic          wr_full,
    output logic          wr_overflow,
    input  logic          rd_accept,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          rd_last,
    output logic          rd_empty,
    output logic          rd_aempty,
    output logic          rd_underflow
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [PW-1:0] wgray;
    logic [PW-1:0] rgray;
    logic [PW-1:0] wgray_rd;
    logic [PW-1:0] rgray_wr;
    logic [DW:0]   head;

    pcf_wr_ctl #(.AW(AW)) u_wr (
        .clk        (wr_clk),
        .rst_n      (rst_n),
        .push       (wr_valid),
        .rgray_sync (rgray_wr),
        .we         (we),
        .waddr      (waddr),
        .wgray      (wgray),
        .full       (wr_full),
        .overflow   (wr_overflow)
    );

    pcf_mem #(.W(DW + 1), .AW(AW)) u_mem (
        .wr_clk (wr_clk),
        .we     (we),
        .waddr  (waddr),
        .wdata  ({wr_last, wr_data}),
        .raddr  (raddr),
        .rdata  (head)
    );

    pcf_sync #(.W(PW)) u_w2r (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (wgray),
        .q     (wgray_rd)
    );

    pcf_sync #(.W(PW)) u_r2w (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .d     (rgray),
        .q     (rgray_wr)
    );

    pcf_rd_ctl #(.DW(DW), .AW(AW)) u_rd (
        .clk        (rd_clk),
        .rst_n      (rst_n),
        .accept     (rd_accept),
        .wgray_sync (wgray_rd),
        .head       (head),
        .raddr      (raddr),
        .rgray      (rgray),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .rd_last    (rd_last),
        .empty      (rd_empty),
        .aempty     (rd_aempty),
        .underflow  (rd_underflow)
    );
endmodule

// File: tb/tb_pcf_top.sv
module tb_pcf_top;
    localparam int TCLK  = 10;
    localparam int DW    = 8;
    localparam int DEPTH = 8;
    localparam int NVEC  = 6;
    localparam int VEC_LEN  [NVEC] = '{2, 3, 5, 8, 4, 6};
    localparam int VEC_BASE [NVEC] = '{8'h10, 8'h20, 8'h40, 8'h80, 8'hC0, 8'hF8};

    logic          wr_clk, rd_clk, rst_n;
    logic          wr_valid, wr_last, rd_accept;
    logic [DW-1:0] wr_data;
    logic          wr_full, wr_overflow;
    logic          rd_valid, rd_last, rd_empty, rd_aempty, rd_underflow;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int fails  = 0;

    pcf_top #(.DW(DW), .DEPTH(DEPTH)) dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last),
        .wr_full(wr_full), .wr_overflow(wr_overflow),
        .rd_accept(rd_accept), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_last(rd_last), .rd_empty(rd_empty), .rd_aempty(rd_aempty),
        .rd_underflow(rd_underflow)
    );

    initial begin
        wr_clk = 1'b0;
        forever #(TCLK / 2) wr_clk = ~wr_clk;
    end
    initial begin
        rd_clk = 1'b0;
        #3;
        forever #(TCLK / 2) rd_clk = ~rd_clk;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic rd_wait(input int n);
        for (int i = 0; i < n; i++) @(negedge rd_clk);
    endtask

    task automatic push_word(input logic [DW-1:0] d, input logic l);
        @(negedge wr_clk);
        wr_valid = 1'b1; wr_data = d; wr_last = l;
        @(negedge wr_clk);
        wr_valid = 1'b0; wr_last = 1'b0;
    endtask

    task automatic push_packet(input int len, input int base);
        @(negedge wr_clk);
        for (int i = 0; i < len; i++) begin
            wr_valid = 1'b1;
            wr_data  = DW'(base + i);
            wr_last  = (i == len - 1);
            @(negedge wr_clk);
        end
        wr_valid = 1'b0; wr_last = 1'b0;
    endtask

    task automatic collect_packet(input int len, input int base, input string tag);
        int waited = 0;
        @(negedge rd_clk);
        while (!rd_valid && waited < 60) begin
            @(negedge rd_clk);
            waited++;
        end
        check(rd_valid == 1'b1, {tag, " R2 packet started"}, rd_valid, 1);
        for (int i = 0; i < len; i++) begin
            if (i > 0) @(negedge rd_clk);
            check(rd_valid == 1'b1, {tag, " R3 no gap"}, rd_valid, 1);
            check(rd_data == DW'(base + i), {tag, " R1 data"}, rd_data, (base + i) % 256);
            check(rd_last == (i == len - 1), {tag, " R1 end marker"}, rd_last, (i == len - 1));
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        #(TCLK * 3 + 1);
        check(rd_empty == 1'b1 && rd_aempty == 1'b1, "R9 reset empty flags", {rd_empty, rd_aempty}, 3);
        check(rd_valid == 1'b0 && wr_full == 1'b0, "R9 reset valid/full", {rd_valid, wr_full}, 0);
        check(wr_overflow == 1'b0 && rd_underflow == 1'b0, "R9 reset errors",
              {wr_overflow, rd_underflow}, 0);
        rst_n = 1'b1;
        rd_wait(3);
    endtask

    initial begin
        #(TCLK * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wr_valid = 1'b0; wr_last = 1'b0; wr_data = '0; rd_accept = 1'b0;
        do_reset();

        // vector table: packet length and first word, checked word by word
        rd_accept = 1'b1;
        for (int v = 0; v < NVEC; v++) begin
            fork
                push_packet(VEC_LEN[v], VEC_BASE[v]);
                collect_packet(VEC_LEN[v], VEC_BASE[v], "table");
            join
            rd_wait(4);
        end
        check(rd_underflow == 1'b0, "R7 no underflow on steady packets", rd_underflow, 0);

        // back-to-back packets
        fork
            begin
                push_packet(3, 8'h31);
                push_packet(4, 8'h51);
            end
            begin
                collect_packet(3, 8'h31, "b2b first");
                collect_packet(4, 8'h51, "b2b second");
            end
        join
        rd_wait(6);
        check(rd_empty == 1'b1, "R4 empty after drain", rd_empty, 1);

        // a single word is held back
        push_word(8'hA0, 1'b0);
        for (int i = 0; i < 10; i++) begin
            @(negedge rd_clk);
            check(rd_valid == 1'b0, "R2 single word held", rd_valid, 0);
        end
        check(rd_empty == 1'b0 && rd_aempty == 1'b1, "R5 one word aempty", {rd_empty, rd_aempty}, 1);
        fork
            push_word(8'hA1, 1'b1);
            collect_packet(2, 8'hA0, "held pair");
        join
        rd_wait(6);

        // fill one word at a time with the consumer not ready
        rd_accept = 1'b0;
        for (int c = 1; c <= DEPTH; c++) begin
            push_word(DW'(8'h60 + c - 1), c == DEPTH);
            rd_wait(6);
            check(rd_empty == 1'b0, "R4 not empty while filling", rd_empty, 0);
            check(rd_aempty == (c <= 1), "R5 aempty while filling", rd_aempty, (c <= 1));
        end
        check(wr_full == 1'b1, "R6 full at depth", wr_full, 1);
        push_word(8'hEE, 1'b1);
        check(wr_overflow == 1'b1, "R6 overflow sticky set", wr_overflow, 1);
        check(wr_full == 1'b1, "R6 still full after drop", wr_full, 1);

        // drain, dropping accept mid-packet
        @(negedge rd_clk);
        rd_accept = 1'b1;
        for (int k = 1; k <= DEPTH; k++) begin
            @(negedge rd_clk);
            if (k == 2) rd_accept = 1'b0;
            check(rd_valid == 1'b1, "R8 R3 drain word present", rd_valid, 1);
            check(rd_data == DW'(8'h60 + k - 1), "R1 drain data", rd_data, 8'h60 + k - 1);
            check(rd_last == (k == DEPTH), "R1 drain marker", rd_last, (k == DEPTH));
            check(rd_aempty == ((DEPTH - k) <= 1), "R5 aempty while draining", rd_aempty,
                  ((DEPTH - k) <= 1));
            check(rd_empty == ((DEPTH - k) == 0), "R4 empty while draining", rd_empty,
                  ((DEPTH - k) == 0));
        end
        @(negedge rd_clk);
        check(rd_valid == 1'b0, "R6 dropped word never appears", rd_valid, 0);
        rd_wait(6);
        check(rd_empty == 1'b1 && rd_valid == 1'b0, "R6 FIFO empty after drop", {rd_empty, rd_valid}, 2);
        check(wr_overflow == 1'b1, "R6 overflow still set", wr_overflow, 1);

        // mid-packet starvation
        rd_accept = 1'b1;
        push_packet(0, 0);
        @(negedge wr_clk);
        wr_valid = 1'b1; wr_data = 8'h70; wr_last = 1'b0;
        @(negedge wr_clk);
        wr_data = 8'h71;
        @(negedge wr_clk);
        wr_valid = 1'b0;
        rd_wait(12);
        check(rd_underflow == 1'b1, "R7 underflow set", rd_underflow, 1);
        fork
            push_word(8'h72, 1'b1);
            collect_packet(1, 8'h72, "R7 resume");
        join
        rd_wait(4);
        check(rd_underflow == 1'b1, "R7 underflow sticky", rd_underflow, 1);

        do_reset();
        fork
            push_packet(3, 8'h90);
            collect_packet(3, 8'h90, "after reset");
        join

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule